// File: doc/BRIEF.md
# Block-Framed Word Stream Receiver

This receiver accepts a stream of 16-bit frame words, one frame per block, and turns each frame back into a block of wide data words for a FIFO-style consumer. Each frame opens with a sequence number and a timestamp, carries one or more data words split into 16-bit halves, and closes with a CRC-16 word. The receiver rebuilds the wide words and keeps the whole block in an internal buffer until its CRC has been checked. Only a block that passes the check is released to the output.

The consumer pulls words with a request input. Each released word carries first-word and last-word markers. A lost marker appears on the first word of a block when earlier blocks went missing: either a sequence number was skipped, or a frame was thrown away because it was corrupt or malformed.

For every accepted block the receiver also gives a latency figure. This is the local reference time at the timestamp word minus the timestamp itself.

Top module: `stream_block_rx`

## Requirements
- R1: After reset `out_valid`, `out_first`, `out_last`, `out_lost` and `lat_valid` are low and `in_ready` is high.
- R2: A frame is, in order: the sequence word, the timestamp word, DATA_W/16 halves for each data word, and the CRC word. The CRC word is marked by `in_eof`. The first half of each data word received is its most significant half.
- R3: A word is presented (`out_valid` high) only in the cycle after a cycle in which `out_req` was high. With `out_req` held high, one buffered word leaves per cycle.
- R4: `out_first` is high with the first word of each block and `out_last` with its final word. Both are high on a one-word block.
- R5: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is taken over all frame words before the CRC word, each word MSB first, with no final inversion. A frame whose CRC word differs produces no output words and no latency pulse.
- R6: `out_lost` is high with the first word of an accepted block when any of these holds: its sequence number is not the last accepted sequence number plus one (mod 2^16); or a frame was discarded since the last accepted block. The first accepted block after reset is otherwise not flagged. `out_lost` is never high without `out_first`.
- R7: For each accepted block `lat_valid` pulses for one cycle, in the cycle after the CRC word is taken. `lat_value` then equals `ref_time` sampled with the timestamp word minus the timestamp, mod 2^16.
- R8: `in_ready` is low while the free buffer space, counting only accepted blocks not yet read, is less than MAX_WORDS words. The buffer never holds more than DEPTH words.
- R9: A frame whose CRC word arrives before any data word, or part way through a data word, is discarded and counts as lost.
- R10: `out_first`, `out_last` and `out_lost` are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base of `ref_time` |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame word present |
| in_word | input | 16 | Frame word |
| in_eof | input | 1 | This word is the closing CRC word |
| in_ready | output | 1 | Receiver takes a frame word this cycle |
| ref_time | input | 16 | Local reference time count |
| out_req | input | 1 | Consumer allows a word in the next cycle |
| out_valid | output | 1 | `out_data` holds a word |
| out_data | output | DATA_W | Rebuilt data word |
| out_first | output | 1 | First word of a block |
| out_last | output | 1 | Last word of a block |
| out_lost | output | 1 | Blocks were lost before this one |
| lat_value | output | 16 | Transport latency of the last accepted block |
| lat_valid | output | 1 | One-cycle qualifier of `lat_value` |

## Verification
A stale commit pointer or a rewind that goes wrong shows up at the output in one of two ways. Either words from a rejected frame appear, or good words go missing. The bench sees either as soon as the next good block drains, a few tens of cycles later. A half counter that slips swaps halves inside the first rebuilt word. A sequence tracker that goes wrong flips `out_lost` on the very next accepted block. Wrong space accounting shows as `in_ready` staying high or low at the moment the second full block is committed.

// File: rtl/stream_block_rx.sv
module stream_block_rx #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int MAX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  input  logic              in_eof,
  output logic              in_ready,
  input  logic [15:0]       ref_time,
  input  logic              out_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              out_lost,
  output logic [15:0]       lat_value,
  output logic              lat_valid
);
  localparam int HALVES = DATA_W / 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int HCW    = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int WCW    = $clog2(MAX_WORDS + 1);
  localparam int EW     = DATA_W + 3;

  typedef enum logic [1:0] {P_SEQ, P_TS, P_DATA} phase_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  phase_t            phase;
  logic [15:0]       crc, blk_seq, blk_lat, exp_seq;
  logic [DATA_W-1:0] sh, pend;
  logic [HCW-1:0]    hc;
  logic [WCW-1:0]    wc;
  logic              have_pend, pend_first, bad, blk_lost, have_prev, lost_pend;
  logic [AW:0]       wr_ptr, cm_ptr, rd_ptr;
  logic [EW-1:0]     mem [DEPTH];

  wire              take      = in_valid && in_ready;
  wire [DATA_W-1:0] full_word = DATA_W'({sh, in_word});
  wire              word_done = (phase == P_DATA) && (hc == HCW'(HALVES - 1));
  wire              at_max    = (wc == WCW'(MAX_WORDS));
  wire              frame_ok  = in_eof && (phase == P_DATA) && (hc == '0) && have_pend
                                && !bad && (in_word == crc);
  wire              we        = take && have_pend && !bad &&
                                ((!in_eof && word_done && !at_max) || frame_ok);
  wire [EW-1:0]     wdata     = {blk_lost && pend_first, pend_first, in_eof, pend};
  wire              can_read  = out_req && (rd_ptr != cm_ptr);

  assign in_ready = ((AW+1)'(DEPTH) - (cm_ptr - rd_ptr)) >= (AW+1)'(MAX_WORDS);

  always_ff @(posedge clk)
    if (we) mem[wr_ptr[AW-1:0]] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= P_SEQ;
      crc        <= 16'hFFFF;
      blk_seq    <= '0;
      blk_lat    <= '0;
      exp_seq    <= '0;
      sh         <= '0;
      pend       <= '0;
      hc         <= '0;
      wc         <= '0;
      have_pend  <= 1'b0;
      pend_first <= 1'b0;
      bad        <= 1'b0;
      blk_lost   <= 1'b0;
      have_prev  <= 1'b0;
      lost_pend  <= 1'b0;
      wr_ptr     <= '0;
      cm_ptr     <= '0;
      lat_value  <= '0;
      lat_valid  <= 1'b0;
    end else begin
      lat_valid <= 1'b0;
      if (take) begin
        if (in_eof) begin
          phase <= P_SEQ;
          if (frame_ok) begin
            wr_ptr    <= wr_ptr + 1'b1;
            cm_ptr    <= wr_ptr + 1'b1;
            exp_seq   <= blk_seq + 16'd1;
            have_prev <= 1'b1;
            lost_pend <= 1'b0;
            lat_value <= blk_lat;
            lat_valid <= 1'b1;
          end else begin
            wr_ptr    <= cm_ptr;
            lost_pend <= 1'b1;
          end
        end else begin
          unique case (phase)
            P_SEQ: begin
              blk_seq   <= in_word;
              blk_lost  <= lost_pend || (have_prev && in_word != exp_seq);
              crc       <= crc_step(16'hFFFF, in_word);
              hc        <= '0;
              wc        <= '0;
              have_pend <= 1'b0;
              bad       <= 1'b0;
              phase     <= P_TS;
            end
            P_TS: begin
              blk_lat <= ref_time - in_word;
              crc     <= crc_step(crc, in_word);
              phase   <= P_DATA;
            end
            default: begin
              crc <= crc_step(crc, in_word);
              sh  <= full_word;
              if (word_done) begin
                hc <= '0;
                if (at_max) bad <= 1'b1;
                else begin
                  wc         <= wc + 1'b1;
                  pend       <= full_word;
                  have_pend  <= 1'b1;
                  pend_first <= (wc == '0);
                  if (have_pend && !bad) wr_ptr <= wr_ptr + 1'b1;
                end
              end else begin
                hc <= hc + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_lost  <= 1'b0;
    end else if (can_read) begin
      {out_lost, out_first, out_last, out_data} <= mem[rd_ptr[AW-1:0]];
      out_valid <= 1'b1;
      rd_ptr    <= rd_ptr + 1'b1;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_lost  <= 1'b0;
    end
  end

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_first || out_last || out_lost)); // R10
  AST_LOST_WITH_FIRST: assert property (@(posedge clk) disable iff (rst)
    out_lost |-> out_first); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= (AW+1)'(DEPTH)); // R8
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_req)); // R3
  AST_LAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lat_valid |=> !lat_valid); // R7
endmodule

// File: tb/tb_stream_block_rx.sv
module tb_stream_block_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH = 16;
  localparam int MAX_WORDS = 8;
  localparam int HALVES = DATA_W / 16;
  localparam int EW = DATA_W + 3;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_eof = 0, out_req = 1;
  logic [15:0] in_word = 0, ref_time = 0;
  logic in_ready, out_valid, out_first, out_last, out_lost, lat_valid;
  logic [DATA_W-1:0] out_data;
  logic [15:0] lat_value;

  int n_chk = 0, n_fail = 0;
  logic [EW-1:0] got_q[$], exp_q[$];
  logic [15:0]   lat_q[$], exp_lat_q[$];

  stream_block_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_WORDS(MAX_WORDS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_eof(in_eof),
    .in_ready(in_ready), .ref_time(ref_time), .out_req(out_req), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last), .out_lost(out_lost),
    .lat_value(lat_value), .lat_valid(lat_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (out_valid) got_q.push_back({out_lost, out_first, out_last, out_data});
    else if (out_first || out_last || out_lost)
      check(0, "R10 flag without valid", {out_lost, out_first, out_last}, 0);
    if (lat_valid) lat_q.push_back(lat_value);
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic put(input logic [15:0] w, input logic eof);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_word = w; in_eof = eof;
    @(posedge clk);
  endtask

  // corrupt: bad CRC (R5); odd: extra half before CRC (R9)
  task automatic send_block(input logic [15:0] seq, input logic [15:0] ts, input int n,
                            input int base, input bit corrupt, input bit odd, input bit lost);
    logic [15:0] c = 16'hFFFF;
    bit good = !corrupt && !odd;
    put(seq, 0); c = crc_upd(c, seq);
    put(ts, 0);  c = crc_upd(c, ts);
    for (int k = 0; k < n; k++) begin
      logic [DATA_W-1:0] dw = '0;
      for (int h = 0; h < HALVES; h++) begin
        logic [15:0] w = 16'(base + k * HALVES + h);
        put(w, 0); c = crc_upd(c, w);
        dw = {dw[DATA_W-17:0], w};
      end
      if (good) exp_q.push_back({lost && k == 0, k == 0, k == n - 1, dw});
    end
    if (odd) begin put(16'h1234, 0); c = crc_upd(c, 16'h1234); end
    put(corrupt ? c ^ 16'h0001 : c, 1);
    @(negedge clk); in_valid = 0; in_eof = 0;
    if (good) exp_lat_q.push_back(ref_time - ts);
  endtask

  task automatic compare(input string req);
    repeat (40) @(negedge clk);
    check(got_q.size() == exp_q.size(), {req, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {req, " word"}, got_q[i], exp_q[i]);
    check(lat_q.size() == exp_lat_q.size(), "R7 latency count", lat_q.size(), exp_lat_q.size());
    for (int i = 0; i < exp_lat_q.size() && i < lat_q.size(); i++)
      check(lat_q[i] == exp_lat_q[i], "R7 latency value", lat_q[i], exp_lat_q[i]);
    got_q.delete(); exp_q.delete(); lat_q.delete(); exp_lat_q.delete();
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!out_valid && !out_first && !out_last && !out_lost, "R1 outputs idle",
          {out_valid, out_first, out_last, out_lost}, 0);
    check(!lat_valid, "R1 latency idle", lat_valid, 0);
    check(in_ready, "R1 ready", in_ready, 1);
  endtask

  task automatic t_basic;
    ref_time = 16'd100;
    send_block(16'd0, 16'd40, 3, 16'h0100, 0, 0, 0);
    compare("R2 R4 three-word block");
    ref_time = 16'd5;
    send_block(16'd1, 16'd10, 1, 16'h0200, 0, 0, 0);
    compare("R4 R7 one-word block, wrapped latency");
  endtask

  task automatic t_gap;
    ref_time = 16'd7;
    send_block(16'd3, 16'd2, 2, 16'h0300, 0, 0, 1);
    send_block(16'd4, 16'd3, 2, 16'h0400, 0, 0, 0);
    compare("R6 sequence gap");
  endtask

  task automatic t_crc;
    send_block(16'd5, 16'd1, 3, 16'h0500, 1, 0, 0);
    compare("R5 corrupt block dropped");
    send_block(16'd5, 16'd1, 3, 16'h0600, 0, 0, 1);
    send_block(16'd6, 16'd1, 1, 16'h0700, 0, 0, 0);
    compare("R6 loss after discarded block");
  endtask

  task automatic t_malformed;
    send_block(16'd7, 16'd0, 2, 16'h0800, 0, 1, 0);
    compare("R9 partial word dropped");
    send_block(16'd7, 16'd0, 2, 16'h0900, 0, 0, 1);
    compare("R9 loss after malformed");
  endtask

  task automatic t_backpressure;
    out_req = 0;
    send_block(16'd8, 16'd0, MAX_WORDS, 16'h1000, 0, 0, 0);
    send_block(16'd9, 16'd0, MAX_WORDS, 16'h2000, 0, 0, 0);
    @(negedge clk);
    check(!in_ready, "R8 ready low when full", in_ready, 0);
    check(!out_valid, "R3 no output without request", out_valid, 0);
    out_req = 1;
    @(negedge clk);
    out_req = 0;
    check(out_valid, "R3 word after one request", out_valid, 1);
    @(negedge clk);
    check(!out_valid, "R3 single word per request", out_valid, 0);
    out_req = 1;
    compare("R3 R8 drain after backpressure");
    check(in_ready, "R8 ready after drain", in_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_gap();
    t_crc();
    t_malformed();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule